// File: doc/BRIEF.md
# BERT Receive Error Counter and Alarm Status

This block holds the receive-side status of a bit-error-rate tester. It takes the comparator's per-bit error strobe, the received bit stream with its valid strobe, the receiver's synchronization level, a pulse reporting that the bit counter has overflowed, and a load-clear control bit. From these it keeps a saturating error count and an all-ones alarm. It also keeps four sticky event latches: sync change, bit error, error-count overflow and bit-count overflow.

Three enable inputs pass the events into a summary status output. A separate gate puts that summary onto an active-low interrupt pin. Software reads the status word and the count through a small read port. A read of the status word clears the latches. Read data is registered and appears one cycle after the read strobe. It holds the values from before that same edge's clear.

The error count stays still until sync is seen for the first time. From then on it keeps counting, even after sync is lost. Software measures a window by giving the load-clear bit one rising edge at the start and reading the count at the end.

Top module: `bert_rx_status`

## Requirements
- R1: After reset the error count reads 0, every latch and the alarm read 0, `stat_sum` is 0 and `int_n` is 1.
- R2: The count rises by exactly one for each cycle with `bit_vld` and `err_bit` both high, but only from the first cycle in which `sync_in` is high. Errors before that cycle, and error strobes without `bit_vld`, leave it unchanged.
- R3: Once armed, the count keeps counting after `sync_in` falls.
- R4: The count stops at 2^CNT_W-1 and does not wrap. The increment that reaches that value sets the error-overflow latch, status bit 4.
- R5: A rising edge of `lc_ctl` clears the count. This clear wins over an increment in the same cycle. Holding `lc_ctl` high does not clear again.
- R6: The all-ones alarm, status bit 1, sets on the ONES_RUN-th consecutive valid one bit (default 31). A run one bit shorter leaves it clear.
- R7: The alarm survives status reads until a valid zero bit has been received. After that, a status read returns 1 and clears it.
- R8: Either edge of `sync_in` sets the sync-change latch, status bit 2. Status bit 0 shows the current `sync_in` level.
- R9: A counted bit error sets the bit-error latch, status bit 3. A `bitcnt_ovf` pulse sets the bit-count-overflow latch, status bit 5.
- R10: A read of address 0 returns the status word on `rd_data` one cycle after `rd_stb` and clears the event latches. An event that arrives in the read cycle stays latched.
- R11: `stat_sum` is the OR of sync change AND `ie_sync`, bit error AND `ie_err`, and either overflow AND `ie_ovf`. `int_n` is low only when both `stat_sum` and `int_en` are high.
- R12: A read of address 1 returns the count, zero-extended, and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Received bit and error strobe valid |
| rx_bit | input | 1 | Received data bit |
| err_bit | input | 1 | Received bit was in error |
| sync_in | input | 1 | Receiver is synchronized |
| bitcnt_ovf | input | 1 | Bit counter overflow pulse |
| lc_ctl | input | 1 | Load-clear control, acts on its rising edge |
| ie_sync | input | 1 | Sync change event enable |
| ie_err | input | 1 | Bit error event enable |
| ie_ovf | input | 1 | Overflow events enable |
| int_en | input | 1 | Summary-to-interrupt gate |
| rd_stb | input | 1 | Single-cycle read strobe |
| rd_addr | input | ADDR_W | 0 = status word, 1 = error count |
| rd_data | output | DATA_W | Registered read data |
| stat_sum | output | 1 | OR of enabled events |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench drives two pairs of functions into the same cycle.

- **Clear against increment.** A rising edge of the load-clear bit is given together with a counted error. The count read back afterwards must be zero, and a further error while the bit stays high must give exactly one.
- **Clear-on-read against a new event.** A status read is issued while an error strobe is valid. The word returned must not yet show the event, and the following read must show it.

// File: rtl/bert_stat_pkg.sv
package bert_stat_pkg;
   localparam int STAT_SYNC = 0;
   localparam int STAT_ONES = 1;
   localparam int STAT_SCHG = 2;
   localparam int STAT_BERR = 3;
   localparam int STAT_ECOV = 4;
   localparam int STAT_BCOV = 5;
   localparam int STAT_BITS = 6;
   // event latch slots
   localparam int EV_SCHG  = 0;
   localparam int EV_BERR  = 1;
   localparam int EV_ECOV  = 2;
   localparam int EV_BCOV  = 3;
   localparam int NUM_EVT  = 4;
   localparam int ADDR_STAT = 0;
   localparam int ADDR_CNT  = 1;
endpackage

// File: rtl/bert_evt_latch.sv
module bert_evt_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      q_q <= 1'b0;
      else if (set_i)  q_q <= 1'b1;
      else if (clr_i)  q_q <= 1'b0;
   end

   assign q_o = q_q;

   // R10
   evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   // R10
   evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/bert_err_cnt.sv
module bert_err_cnt #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             err_i,
   input  logic             lc_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             err_o,
   output logic             sat_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_PRE = {{(CNT_W-1){1'b1}}, 1'b0};

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             lc_q;
   logic             live;
   logic             inc;
   logic             clr;

   assign live = armed_q | arm_i;
   assign inc  = err_i & live;
   assign clr  = lc_i & ~lc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         lc_q    <= 1'b0;
      end else begin
         lc_q <= lc_i;
         if (arm_i) armed_q <= 1'b1;
         if (clr)                          cnt_q <= '0;
         else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign err_o = inc;
   assign sat_o = inc & ~clr & (cnt_q == CNT_PRE);

   // R5
   cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
   // R4
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));
   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
   // R3
   arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> armed_q);
endmodule

// File: rtl/bert_ones_det.sv
module bert_ones_det #(
   parameter int RUN_LEN = 31
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vld_i,
   input  logic bit_i,
   input  logic rd_clr_i,
   output logic alm_o
);
   localparam int RUN_W = $clog2(RUN_LEN + 1);
   localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_LEN);
   localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(RUN_LEN - 1);

   logic [RUN_W-1:0] run_q;
   logic             alm_q;
   logic             hit;

   assign hit = vld_i & bit_i & (run_q == RUN_PRE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
         alm_q <= 1'b0;
      end else begin
         if (vld_i) begin
            if (!bit_i)               run_q <= '0;
            else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
         end
         if (hit)                                alm_q <= 1'b1;
         else if (rd_clr_i && run_q != RUN_TOP)  alm_q <= 1'b0;
      end
   end

   assign alm_o = alm_q;

   // R6
   ones_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> alm_o);
   // R7
   ones_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_q && run_q == RUN_TOP) |=> alm_o);
endmodule

// File: rtl/bert_rx_status.sv
module bert_rx_status
   import bert_stat_pkg::*;
#(
   parameter int CNT_W    = 24,
   parameter int ONES_RUN = 31,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld,
   input  logic              rx_bit,
   input  logic              err_bit,
   input  logic              sync_in,
   input  logic              bitcnt_ovf,
   input  logic              lc_ctl,
   input  logic              ie_sync,
   input  logic              ie_err,
   input  logic              ie_ovf,
   input  logic              int_en,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              stat_sum,
   output logic              int_n
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie in 2..DATA_W");
   end
   if (ONES_RUN < 2) begin : g_bad_run
      $error("ONES_RUN must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < STAT_BITS) begin : g_bad_port
      $error("ADDR_W or DATA_W too small");
   end

   logic [CNT_W-1:0]   cnt;
   logic               err_evt;
   logic               sat_evt;
   logic               sync_q;
   logic               rd_clr;
   logic               ones_alm;
   logic [NUM_EVT-1:0] evt_set;
   logic [NUM_EVT-1:0] evt_q;
   logic [DATA_W-1:0]  stat_word;
   logic [DATA_W-1:0]  rd_d;

   assign rd_clr = rd_stb & (rd_addr == ADDR_W'(ADDR_STAT));

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= 1'b0;
      else        sync_q <= sync_in;
   end

   bert_err_cnt #(.CNT_W(CNT_W)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .arm_i (sync_in),
      .err_i (bit_vld & err_bit),
      .lc_i  (lc_ctl),
      .cnt_o (cnt),
      .err_o (err_evt),
      .sat_o (sat_evt)
   );

   bert_ones_det #(.RUN_LEN(ONES_RUN)) i_ones (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld_i    (bit_vld),
      .bit_i    (rx_bit),
      .rd_clr_i (rd_clr),
      .alm_o    (ones_alm)
   );

   assign evt_set[EV_SCHG] = sync_in ^ sync_q;
   assign evt_set[EV_BERR] = err_evt;
   assign evt_set[EV_ECOV] = sat_evt;
   assign evt_set[EV_BCOV] = bitcnt_ovf;

   for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      bert_evt_latch i_latch (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (evt_set[e]),
         .clr_i (rd_clr),
         .q_o   (evt_q[e])
      );
   end

   always_comb begin
      stat_word            = '0;
      stat_word[STAT_SYNC] = sync_in;
      stat_word[STAT_ONES] = ones_alm;
      stat_word[STAT_SCHG] = evt_q[EV_SCHG];
      stat_word[STAT_BERR] = evt_q[EV_BERR];
      stat_word[STAT_ECOV] = evt_q[EV_ECOV];
      stat_word[STAT_BCOV] = evt_q[EV_BCOV];
   end

   always_comb begin
      if (rd_addr == ADDR_W'(ADDR_CNT)) rd_d = DATA_W'(cnt);
      else                              rd_d = stat_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_stb) rd_data <= rd_d;
   end

   assign stat_sum = (evt_q[EV_SCHG] & ie_sync)
                   | (evt_q[EV_BERR] & ie_err)
                   | ((evt_q[EV_ECOV] | evt_q[EV_BCOV]) & ie_ovf);
   assign int_n    = ~(stat_sum & int_en);

   // R11
   int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q == '0) |-> int_n);
   // R8
   sync_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_in != sync_q) |=> evt_q[EV_SCHG]);
endmodule

// File: tb/test_bert_rx_status.sv
module test_bert_rx_status;
   localparam int CW = 8;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n, bit_vld, rx_bit, err_bit, sync_in, bitcnt_ovf, lc_ctl;
   logic ie_sync, ie_err, ie_ovf, int_en, rd_stb;
   logic [1:0]    rd_addr;
   logic [DW-1:0] rd_data;
   logic          stat_sum, int_n;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   bert_rx_status #(.CNT_W(CW)) i_bert_rx_status (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
      .err_bit(err_bit), .sync_in(sync_in), .bitcnt_ovf(bitcnt_ovf),
      .lc_ctl(lc_ctl), .ie_sync(ie_sync), .ie_err(ie_err), .ie_ovf(ie_ovf),
      .int_en(int_en), .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
      .stat_sum(stat_sum), .int_n(int_n)
   );

   // vector: [7]sync [6]vld [5]err [4]lc [3:0]expected count
   localparam logic [7:0] VEC [0:10] = '{
      8'b0110_0000, 8'b1100_0000, 8'b1110_0001, 8'b1010_0001,
      8'b0110_0010, 8'b0110_0011, 8'b0111_0000, 8'b0111_0001,
      8'b0110_0010, 8'b0001_0000, 8'b0110_0001 };

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; bit_vld = 0; rx_bit = 0; err_bit = 0; sync_in = 0;
      bitcnt_ovf = 0; lc_ctl = 0; ie_sync = 0; ie_err = 0; ie_ovf = 0;
      int_en = 0; rd_stb = 0; rd_addr = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic step(input logic s, input logic v, input logic r, input logic e);
      @(negedge clk);
      sync_in = s; bit_vld = v; rx_bit = r; err_bit = e;
   endtask

   task automatic rd(input logic [1:0] a, input logic with_err, output logic [DW-1:0] d);
      @(negedge clk);
      rd_stb = 1; rd_addr = a; bit_vld = with_err; err_bit = with_err; rx_bit = 0;
      @(negedge clk);
      rd_stb = 0; bit_vld = 0; err_bit = 0;
      d = rd_data;
   endtask

   initial begin
      #1_500_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      do_reset();
      // R1 reset state
      @(negedge clk);
      chk("R1 int_n", {31'b0, int_n}, 1);
      chk("R1 stat_sum", {31'b0, stat_sum}, 0);
      rd(0, 0, d); chk("R1 status", d, 0);
      rd(1, 0, d); chk("R1 count", d, 0);

      // R2 R3 R5 R12 table walk
      for (int i = 0; i < 11; i++) begin
         @(negedge clk);
         sync_in = VEC[i][7]; bit_vld = VEC[i][6]; err_bit = VEC[i][5];
         lc_ctl = VEC[i][4]; rx_bit = 0;
         rd(1, 0, d);
         chk($sformatf("R2/R3/R5/R12 vec%0d", i), d, DW'(VEC[i][3:0]));
      end
      rd(1, 0, d); chk("R12 count reread", d, 1);

      // R4 saturation
      do_reset();
      lc_ctl = 0;
      for (int i = 0; i < 254; i++) step(1, 1, 0, 1);
      rd(1, 0, d); chk("R4 count 254", d, 254);
      rd(0, 0, d); chk("R4 no ovf yet", (d >> 4) & 1, 0);
      step(1, 1, 0, 1);
      rd(1, 0, d); chk("R4 count max", d, 255);
      rd(0, 0, d); chk("R4 ovf latched", (d >> 4) & 1, 1);
      step(1, 1, 0, 1); step(1, 1, 0, 1);
      rd(1, 0, d); chk("R4 no wrap", d, 255);

      // R6 R7 all-ones alarm
      do_reset();
      for (int i = 0; i < 30; i++) step(0, 1, 1, 0);
      rd(0, 0, d); chk("R6 short run", (d >> 1) & 1, 0);
      step(0, 1, 1, 0);
      rd(0, 0, d); chk("R6 alarm set", (d >> 1) & 1, 1);
      rd(0, 0, d); chk("R7 held without zero", (d >> 1) & 1, 1);
      step(0, 1, 0, 0);
      rd(0, 0, d); chk("R7 read after zero", (d >> 1) & 1, 1);
      rd(0, 0, d); chk("R7 cleared", (d >> 1) & 1, 0);

      // R8 sync change
      do_reset();
      step(1, 0, 0, 0);
      rd(0, 0, d); chk("R8 rise", d & 32'h5, 32'h5);
      rd(0, 0, d); chk("R8 cleared by read R10", d & 32'h4, 0);
      step(0, 0, 0, 0);
      rd(0, 0, d); chk("R8 fall", d & 32'h5, 32'h4);

      // R9 events
      step(1, 1, 0, 1);
      @(negedge clk); bit_vld = 0; err_bit = 0; bitcnt_ovf = 1;
      @(negedge clk); bitcnt_ovf = 0;
      rd(0, 0, d); chk("R9 bit error and bitcount ovf", d & 32'h28, 32'h28);

      // R10 event in read cycle survives
      rd(0, 0, d); chk("R10 cleared", d & 32'h8, 0);
      rd(0, 1, d); chk("R10 read cycle value", d & 32'h8, 0);
      rd(0, 0, d); chk("R10 event kept", d & 32'h8, 32'h8);

      // R11 enables and gate
      step(1, 1, 0, 1);
      @(negedge clk); bit_vld = 0; err_bit = 0; ie_sync = 1; ie_ovf = 1;
      #1 chk("R11 disabled", {30'b0, stat_sum, int_n}, 32'h1);
      ie_err = 1;
      #1 chk("R11 summary no gate", {30'b0, stat_sum, int_n}, 32'h3);
      int_en = 1;
      #1 chk("R11 int low", {30'b0, stat_sum, int_n}, 32'h2);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule